// File: doc/BRIEF.md
# Multi-Channel Buffered PWM Timer

This block is a register-programmed timer that produces edge-aligned pulse-width modulated outputs on several channels at once. One shared up-counter, slowed by a power-of-two prescaler, sweeps from zero to a programmable modulo and then wraps. Each wrap begins a new period. Every channel compares the running count with its own compare value and drives a high or low level. A per-channel level-select field chooses normal polarity, inverted polarity or off.

Software configures the block through a simple write/read bus with an 8-bit byte address and 32-bit data. Reads are combinational from the address. The modulo and compare values are double-buffered. While the counter is stopped, a written value becomes active at once. While it runs, the value waits in a holding register and loads at the next period start. Reads always return the active value, so software can poll until its new setting has landed.

Channel mode and level changes are not buffered. They reach the output pin on the next cycle. The counter is governed by a two-state machine. State CNT_HALT moves to CNT_RUN on transition GO when the clock-mode field equals 01. State CNT_RUN moves back to CNT_HALT on transition STOP when the field holds any other code.

Top module: `pwm_timer_top`

## Requirements
- R1: After reset every register reads zero, the counter is halted and all outputs are low. The read-only register at 0x04 reports the channel count in bits 7:0.
- R2: The control register at 0x10 holds the prescale in bits 2:0 and the clock mode in bits 4:3. Mode 01 runs the counter; every other mode halts it and the count holds its value. Bit 5 ignores writes and reads as 0.
- R3: While running, the counter advances once every 2^PS clock cycles.
- R4: The count at 0x14 steps from 0 up to the active modulo and then returns to 0, which starts a new period. If the count is above the modulo, it returns to 0 on its next step.
- R5: While halted, a write to the modulo at 0x18 or to a channel compare value at 0x24+8n is active and reads back on the next cycle.
- R6: While running, such a write is held. The active value, which is what reads return, is unchanged until the next period start, and at that start the count is 0.
- R7: The channel control register sits at 0x20+8n. When its mode bits 5:4 are 10 and its level bits 3:2 are 10, the output is high while count < compare value. Level bits 01 give the inverse.
- R8: A compare value of 0 gives a constantly inactive level. A compare value above the modulo gives a constantly active level.
- R9: The output is low when the level bits are 00 or 11, or when the mode bits are not 10. A control write changes the output on the next cycle.
- R10: Channel control bit 7 is a flag that sets whenever the running count equals the compare value. Writing 1 to it clears it, and writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe |
| addr | input | ADDR_W | Byte address for writes and reads |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for addr |
| pwm_out | output | NCH | Channel outputs |

## Verification
The assertions assume that reset is held low across at least one rising edge. They also assume that the prescale field changes only while the counter is halted, so each counter step is exactly one prescaled tick. The stimulus meets both conditions: it always writes a halt before it reprograms the prescale, modulo or channel values. The only settings it rewrites while the counter runs are the buffered values and the channel control fields.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int OFS_PARAM   = 32'h04;
    localparam int OFS_GLOBAL  = 32'h08;
    localparam int OFS_SC      = 32'h10;
    localparam int OFS_CNT     = 32'h14;
    localparam int OFS_MOD     = 32'h18;
    localparam int OFS_CH_BASE = 32'h20;
    localparam int CH_STRIDE   = 8;
    localparam int CH_VAL_OFS  = 4;

    localparam int PS_W      = 3;
    localparam int CMODE_LSB = 3;

    localparam logic [1:0] CMODE_RUN = 2'b01;
    localparam logic [1:0] MS_EDGE   = 2'b10;
    localparam logic [1:0] EL_NORMAL = 2'b10;
    localparam logic [1:0] EL_INVERT = 2'b01;

    typedef enum logic {
        CNT_HALT,
        CNT_RUN
    } cnt_state_e;

    typedef enum logic [1:0] {
        CH_OFF,
        CH_NORMAL,
        CH_INVERT
    } ch_mode_e;

    function automatic ch_mode_e decode_mode(input logic [1:0] ms, input logic [1:0] el);
        ch_mode_e m;
        m = CH_OFF;
        if (ms == MS_EDGE) begin
            if (el == EL_NORMAL)      m = CH_NORMAL;
            else if (el == EL_INVERT) m = CH_INVERT;
        end
        return m;
    endfunction

endpackage

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cmode,
    input  logic [PS_W-1:0]  ps,
    input  logic [CNT_W-1:0] mod_act,
    output logic             running,
    output logic             tick,
    output logic             period_start,
    output logic [CNT_W-1:0] cnt
);

    localparam int DIV_W = (1 << PS_W) - 1;

    cnt_state_e       state_q, state_d;
    logic [DIV_W-1:0] pre_q;
    logic [DIV_W-1:0] pre_lim;
    logic [CNT_W-1:0] cnt_q;

    assign pre_lim = DIV_W'((32'd1 << ps) - 32'd1);
    assign cnt     = cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CNT_HALT;
        else        state_q <= state_d;
    end

    // transitions GO and STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CNT_HALT: if (cmode == CMODE_RUN) state_d = CNT_RUN;
            CNT_RUN:  if (cmode != CMODE_RUN) state_d = CNT_HALT;
            default:  state_d = CNT_HALT;
        endcase
    end

    // state outputs
    always_comb begin
        running      = (state_q == CNT_RUN);
        tick         = running && (pre_q >= pre_lim);
        period_start = tick && (cnt_q >= mod_act);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else begin
            if (!running || tick) pre_q <= '0;
            else                  pre_q <= pre_q + 1'b1;
            if (period_start)     cnt_q <= '0;
            else if (tick)        cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_timer_pkg::*;
#(
    parameter int IDX    = 0,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    input  logic              running,
    input  logic              period_start,
    input  logic [CNT_W-1:0]  cnt,
    output logic [7:0]        rd_ctrl,
    output logic [CNT_W-1:0]  rd_val,
    output logic [3:0]        cfg,
    output logic              pwm_o
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CH_BASE + IDX * CH_STRIDE);
    localparam logic [ADDR_W-1:0] A_VAL  = ADDR_W'(OFS_CH_BASE + IDX * CH_STRIDE + CH_VAL_OFS);

    logic [1:0]       ms_q, el_q;
    logic             flag_q;
    logic [CNT_W-1:0] val_sh, val_act;
    logic             wr_ctrl, wr_val, active;
    ch_mode_e         mode;

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_val  = wr_en && (addr == A_VAL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ms_q    <= '0;
            el_q    <= '0;
            flag_q  <= 1'b0;
            val_sh  <= '0;
            val_act <= '0;
        end else begin
            if (wr_ctrl) begin
                ms_q <= wr_data[5:4];
                el_q <= wr_data[3:2];
            end
            if (running && (cnt == val_act))  flag_q <= 1'b1;
            else if (wr_ctrl && wr_data[7])   flag_q <= 1'b0;
            if (wr_val) val_sh <= wr_data[CNT_W-1:0];
            if (wr_val && !running)   val_act <= wr_data[CNT_W-1:0];
            else if (period_start)    val_act <= val_sh;
        end
    end

    assign mode   = decode_mode(ms_q, el_q);
    assign active = (cnt < val_act);

    always_comb begin
        unique case (mode)
            CH_NORMAL: pwm_o = active;
            CH_INVERT: pwm_o = !active;
            default:   pwm_o = 1'b0;
        endcase
    end

    assign rd_ctrl = {flag_q, 1'b0, ms_q, el_q, 2'b00};
    assign rd_val  = val_act;
    assign cfg     = {ms_q, el_q};

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_timer_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [31:0]               wr_data,
    input  logic                      running,
    input  logic                      period_start,
    input  logic [CNT_W-1:0]          cnt,
    input  logic [NCH-1:0][7:0]       ch_rd_ctrl,
    input  logic [NCH-1:0][CNT_W-1:0] ch_rd_val,
    output logic [PS_W-1:0]           ps,
    output logic [1:0]                cmode,
    output logic [CNT_W-1:0]          mod_act,
    output logic [31:0]               rd_data
);

    localparam logic [ADDR_W-1:0] A_PARAM = ADDR_W'(OFS_PARAM);
    localparam logic [ADDR_W-1:0] A_SC    = ADDR_W'(OFS_SC);
    localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(OFS_CNT);
    localparam logic [ADDR_W-1:0] A_MOD   = ADDR_W'(OFS_MOD);

    logic [CNT_W-1:0] mod_sh;
    logic             wr_sc, wr_mod;

    assign wr_sc  = wr_en && (addr == A_SC);
    assign wr_mod = wr_en && (addr == A_MOD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps      <= '0;
            cmode   <= '0;
            mod_sh  <= '0;
            mod_act <= '0;
        end else begin
            if (wr_sc) begin
                ps    <= wr_data[PS_W-1:0];
                cmode <= wr_data[CMODE_LSB+1:CMODE_LSB];
            end
            if (wr_mod) mod_sh <= wr_data[CNT_W-1:0];
            if (wr_mod && !running) mod_act <= wr_data[CNT_W-1:0];
            else if (period_start)  mod_act <= mod_sh;
        end
    end

    always_comb begin
        rd_data = '0;
        if (addr == A_PARAM) begin
            rd_data[7:0] = 8'(NCH);
        end else if (addr == A_SC) begin
            rd_data[PS_W-1:0]                = ps;
            rd_data[CMODE_LSB+1:CMODE_LSB]   = cmode;
        end else if (addr == A_CNT) begin
            rd_data = 32'(cnt);
        end else if (addr == A_MOD) begin
            rd_data = 32'(mod_act);
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (addr == ADDR_W'(OFS_CH_BASE + i * CH_STRIDE))
                    rd_data = 32'(ch_rd_ctrl[i]);
                if (addr == ADDR_W'(OFS_CH_BASE + i * CH_STRIDE + CH_VAL_OFS))
                    rd_data = 32'(ch_rd_val[i]);
            end
        end
    end

endmodule

// File: rtl/pwm_timer_top.sv
module pwm_timer_top
    import pwm_timer_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic [NCH-1:0]    pwm_out
);

    logic                      running, tick, period_start;
    logic [CNT_W-1:0]          cnt, mod_act;
    logic [PS_W-1:0]           ps;
    logic [1:0]                cmode;
    logic [NCH-1:0][7:0]       ch_rd_ctrl;
    logic [NCH-1:0][CNT_W-1:0] ch_rd_val;
    logic [NCH-1:0][3:0]       ch_cfg;

    pwm_regs #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .running(running), .period_start(period_start), .cnt(cnt),
        .ch_rd_ctrl(ch_rd_ctrl), .ch_rd_val(ch_rd_val),
        .ps(ps), .cmode(cmode), .mod_act(mod_act), .rd_data(rd_data)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cmode(cmode), .ps(ps), .mod_act(mod_act),
        .running(running), .tick(tick), .period_start(period_start), .cnt(cnt)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_channel #(.IDX(g), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
            .running(running), .period_start(period_start), .cnt(cnt),
            .rd_ctrl(ch_rd_ctrl[g]), .rd_val(ch_rd_val[g]), .cfg(ch_cfg[g]),
            .pwm_o(pwm_out[g])
        );
    end

endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk #(
    parameter int NCH   = 4,
    parameter int CNT_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 running,
    input logic                 tick,
    input logic                 period_start,
    input logic [CNT_W-1:0]     cnt,
    input logic [CNT_W-1:0]     mod_act,
    input logic [NCH-1:0][3:0]  ch_cfg,
    input logic [NCH-1:0]       pwm_out
);

    // R2
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> $stable(cnt))
        else $error("count moved while halted");

    // R4
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> (cnt == '0))
        else $error("count not zero after period start");

    // R4
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !period_start) |=> (cnt == CNT_W'($past(cnt) + 1'b1)))
        else $error("count did not step by one");

    // R6
    mod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !period_start) |=> $stable(mod_act))
        else $error("active modulo changed mid-period");

    for (genvar g = 0; g < NCH; g++) begin : g_off
        // R9
        off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((ch_cfg[g][3:2] != 2'b10) || (ch_cfg[g][1:0] == 2'b00) || (ch_cfg[g][1:0] == 2'b11))
            |-> !pwm_out[g])
            else $error("disabled channel output high");
    end

endmodule

bind pwm_timer_top pwm_timer_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .running(running), .tick(tick),
    .period_start(period_start), .cnt(cnt), .mod_act(mod_act),
    .ch_cfg(ch_cfg), .pwm_out(pwm_out)
);

// File: tb/pwm_timer_top_tb.sv
`timescale 1ns/100ps
module pwm_timer_top_tb;

    localparam int NCH = 4;
    localparam logic [7:0] A_PARAM = 8'h04, A_SC = 8'h10, A_CNT = 8'h14, A_MOD = 8'h18;
    localparam logic [7:0] A_C0 = 8'h20, A_V0 = 8'h24, A_C1 = 8'h28, A_V1 = 8'h2C;
    localparam int NVEC = 10;
    // {modulo, compare, prescale, ch0 control}
    localparam logic [47:0] VEC [NVEC] = '{
        48'h0009_0004_00_28, 48'h0009_0004_00_24, 48'h0007_0000_00_28,
        48'h0005_0009_00_28, 48'h000F_0008_02_28, 48'h0006_0003_01_24,
        48'h0009_0004_00_20, 48'h0009_0004_00_2C, 48'h0009_0004_00_18,
        48'h0004_0000_01_24
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [NCH-1:0] pwm_out;
    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_timer_top #(.NCH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #0.5 d = rd_data;
    endtask

    function automatic bit exp_out(input logic [7:0] c, input int v, input int n);
        bit act;
        act = (n < v);
        if (c[5:4] != 2'b10) return 1'b0;
        if (c[3:2] == 2'b10) return act;
        if (c[3:2] == 2'b01) return !act;
        return 1'b0;
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, d2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(pwm_out == '0, "R1 outputs", 32'(pwm_out), 0);
        rd(A_PARAM, d); chk(d[7:0] == 8'(NCH), "R1 channel count", d, NCH);
        rd(A_SC, d);    chk(d == 0, "R1 control", d, 0);
        rd(A_MOD, d);   chk(d == 0, "R1 modulo", d, 0);
        rd(A_CNT, d);   chk(d == 0, "R1 count", d, 0);
        rd(A_C0, d);    chk(d == 0, "R1 ch control", d, 0);
        rd(A_V0, d);    chk(d == 0, "R1 ch value", d, 0);

        // vector table: R3 R4 R7 R8 R9
        for (int k = 0; k < NVEC; k++) begin
            int m, v, p, n, prev, run, maxc, out_err, pre_err, step_err;
            bit seen_chg, seen_wrap;
            logic [7:0] c;
            m = int'(VEC[k][47:32]); v = int'(VEC[k][31:16]);
            p = int'(VEC[k][15:8]);  c = VEC[k][7:0];
            wr(A_SC, 0);
            repeat (2) @(negedge clk);
            wr(A_MOD, m); wr(A_V0, v); wr(A_C0, 32'(c) | 32'h80);
            wr(A_V1, 3);  wr(A_C1, 32'h28);
            wr(A_SC, 32'h8 | p);
            prev = -1; run = 0; maxc = 0; out_err = 0; pre_err = 0; step_err = 0;
            seen_chg = 0; seen_wrap = 0;
            n = (m + 1) * (1 << p) * 3 + 8;
            for (int t = 0; t < n; t++) begin
                @(negedge clk);
                addr = A_CNT;
                #0.5;
                if (pwm_out[0] != exp_out(c, v, int'(rd_data)) ||
                    pwm_out[1] != exp_out(8'h28, 3, int'(rd_data))) out_err++;
                if (prev >= 0 && int'(rd_data) != prev) begin
                    if (seen_chg && run != (1 << p)) pre_err++;
                    if (int'(rd_data) == 0) begin
                        if (prev < m) step_err++;
                        seen_wrap = 1;
                    end else if (int'(rd_data) != prev + 1) step_err++;
                    seen_chg = 1; run = 1;
                end else run++;
                if (seen_wrap && int'(rd_data) > maxc) maxc = int'(rd_data);
                prev = int'(rd_data);
            end
            chk(out_err == 0, "R7 R8 R9 output level", out_err, 0);
            chk(pre_err == 0, "R3 prescale step length", pre_err, 0);
            chk(step_err == 0 && maxc == m, "R4 count range", maxc, m);
        end

        // R2: non-run mode halts, bit 5 reads 0
        wr(A_SC, 32'h30);
        repeat (2) @(negedge clk);
        rd(A_SC, d); chk(d == 32'h10, "R2 control readback", d, 32'h10);
        rd(A_CNT, d); repeat (5) @(negedge clk); rd(A_CNT, d2);
        chk(d == d2, "R2 count holds", d2, d);

        // R5: immediate when halted
        wr(A_MOD, 20); rd(A_MOD, d); chk(d == 20, "R5 modulo immediate", d, 20);
        wr(A_V0, 11);  rd(A_V0, d);  chk(d == 11, "R5 value immediate", d, 11);

        // R6: buffered while running
        wr(A_MOD, 9); wr(A_V0, 4); wr(A_C0, 32'h28); wr(A_SC, 32'h8);
        repeat (20) @(negedge clk);
        wr(A_V0, 7);
        rd(A_V0, d); chk(d == 4, "R6 value held", d, 4);
        begin
            bit got;
            got = 0;
            for (int t = 0; t < 30 && !got; t++) begin
                @(negedge clk);
                addr = A_V0; #0.5 d = rd_data;
                addr = A_CNT; #0.5 d2 = rd_data;
                if (d == 7) begin
                    got = 1;
                    chk(d2 == 0, "R6 load at period start", d2, 0);
                end
            end
            chk(got, "R6 value eventually loads", d, 7);
        end
        wr(A_MOD, 5);
        rd(A_MOD, d); chk(d == 9, "R6 modulo held", d, 9);

        // R10 flag
        repeat (30) @(negedge clk);
        wr(A_SC, 0);
        repeat (2) @(negedge clk);
        rd(A_C0, d); chk(d[7] == 1'b1, "R10 flag set", d, 32'hA8);
        wr(A_C0, 32'h28); rd(A_C0, d); chk(d[7] == 1'b1, "R10 write 0 keeps flag", d, 32'hA8);
        wr(A_C0, 32'hA8); rd(A_C0, d); chk(d[7] == 1'b0, "R10 write 1 clears", d, 32'h28);

        // R9 immediate level change while running; R8 constant active
        wr(A_MOD, 9); wr(A_V0, 12); wr(A_SC, 32'h8);
        repeat (3) @(negedge clk);
        chk(pwm_out[0] == 1'b1, "R8 constant active", 32'(pwm_out[0]), 1);
        wr(A_C0, 32'h2C);
        chk(pwm_out[0] == 1'b0, "R9 off next cycle", 32'(pwm_out[0]), 0);
        wr(A_C0, 32'h24);
        chk(pwm_out[0] == 1'b0, "R9 inverted constant", 32'(pwm_out[0]), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule